// File: doc/BRIEF.md
# Next Program Counter Unit

This unit sits beside the decoder of an 8-bit microcontroller core and works out where the next instruction fetch goes. For each instruction the decoder presents the start address, the opcode, the instruction length and up to two operand bytes. The core also supplies the accumulator, the data pointer, the carry flag, a selected bit value, the two compare operands and the loop counter value.

From these the unit classifies the control transfer. The classes are: sequential flow, in-page absolute jump or call, long jump or call, short or conditional relative branch, and indirect jump through the data pointer. It then selects either the branch target or the fall-through address.

All results are captured in one register stage when `step_i` is high and held otherwise. The registered results are the next fetch address, a branch-taken flag, a call flag with its return address, a request to clear the tested bit, the carry flag as updated by compare-and-branch, and the decremented loop counter. Address arithmetic wraps modulo 2^16 and raises no flag.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted and after its release until the first step, every output is zero: `valid_o`, `npc_o`, `taken_o`, `call_o`, `ret_addr_o`, `bit_clr_o`, `cy_o` and `cnt_o`.
- R2: Each step is reported one clock later. For an opcode that is not a control transfer, `npc_o` equals `pc_i + len_i` (modulo 2^16) and `taken_o` is 0.
- R3: For an opcode whose low five bits are 00001 (an in-page jump when bit 4 is 0, a call when bit 4 is 1), the target is assembled from three fields. Bits 15..11 are taken from `pc_i + len_i`. Bits 10..8 are opcode bits 7..5. Bits 7..0 are `opa_i`.
- R4: For opcodes 0x02 (long jump) and 0x12 (long call), the target is `{opa_i, opb_i}`, with the high byte first.
- R5: `ret_addr_o` always equals `pc_i + len_i`. `call_o` is 1 only for the in-page call opcodes and for 0x12, and every call is taken.
- R6: Relative branches add a sign-extended displacement (−128..+127) to `pc_i + len_i`, modulo 2^16. The displacement is `opb_i` when `len_i` is 3 and `opa_i` otherwise. Opcode 0x80 always branches.
- R7: The opcodes that test a flag are 0x40, 0x50, 0x60 and 0x70. Opcode 0x40 branches when `cy_i` is 1 and 0x50 when it is 0. Opcode 0x60 branches when `acc_i` is zero and 0x70 when it is nonzero.
- R8: Opcode 0x20 branches when `bit_i` is 1 and 0x30 when it is 0. Opcode 0x10 branches when `bit_i` is 1 and then also raises `bit_clr_o`. `bit_clr_o` is never 1 without a taken branch.
- R9: Opcodes 0xB4..0xBF branch when `cmp_lhs_i` differs from `cmp_rhs_i`, and set `cy_o` to (`cmp_lhs_i < cmp_rhs_i`, unsigned). For every other opcode `cy_o` equals `cy_i`.
- R10: For opcodes 0xD5 and 0xD8..0xDF, `cnt_o` is `cnt_i − 1` with 0x00 wrapping to 0xFF, and the branch is taken only when that value is nonzero.
- R11: Opcode 0x73 targets `dptr_i + acc_i`, with the accumulator treated as unsigned and the sum taken modulo 2^16.
- R12: A cycle with `step_i` low leaves every result output unchanged and gives `valid_o` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Capture results for the presented instruction |
| pc_i | input | 16 | Start address of the instruction |
| opcode_i | input | 8 | First instruction byte |
| len_i | input | 2 | Instruction length from the decoder (1..3) |
| opa_i | input | 8 | Second instruction byte |
| opb_i | input | 8 | Third instruction byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| cy_i | input | 1 | Current carry flag |
| bit_i | input | 1 | Value of the addressed bit |
| cmp_lhs_i | input | 8 | First compare operand |
| cmp_rhs_i | input | 8 | Second compare operand |
| cnt_i | input | 8 | Loop counter value before decrement |
| valid_o | output | 1 | Results below belong to the previous step |
| npc_o | output | 16 | Next fetch address |
| taken_o | output | 1 | Control transfer taken |
| call_o | output | 1 | Instruction is a call |
| ret_addr_o | output | 16 | Address to push for a call |
| bit_clr_o | output | 1 | Request to clear the tested bit |
| cy_o | output | 1 | Carry flag after the instruction |
| cnt_o | output | 8 | Decremented loop counter |

## Verification
The assertions assume that `len_i` matches the opcode as a real decoder would produce it: 1 to 3, with 2 for the in-page forms and 3 for long forms and bit or compare branches. The relative byte selection and the fall-through address are only meaningful under that assumption. They also assume that `step_i` is a single-cycle pulse driven between clock edges. Each directed task presents one instruction with a consistent length and lowers `step_i` before sampling, so the stimulus never leaves that envelope.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [3:0] {
      K_SEQ,
      K_ABS_JMP,
      K_ABS_CALL,
      K_LONG_JMP,
      K_LONG_CALL,
      K_SHORT,
      K_JC,
      K_JNC,
      K_JZ,
      K_JNZ,
      K_JB,
      K_JNB,
      K_JBC,
      K_CJNE,
      K_DJNZ,
      K_IND
   } xfer_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [7:0]  opcode_i,
   output xfer_kind_e  kind_o
);

   always_comb begin
      kind_o = K_SEQ;
      casez (opcode_i)
         8'b???0_0001: kind_o = K_ABS_JMP;
         8'b???1_0001: kind_o = K_ABS_CALL;
         8'h02:        kind_o = K_LONG_JMP;
         8'h12:        kind_o = K_LONG_CALL;
         8'h80:        kind_o = K_SHORT;
         8'h40:        kind_o = K_JC;
         8'h50:        kind_o = K_JNC;
         8'h60:        kind_o = K_JZ;
         8'h70:        kind_o = K_JNZ;
         8'h20:        kind_o = K_JB;
         8'h30:        kind_o = K_JNB;
         8'h10:        kind_o = K_JBC;
         8'b1011_01??: kind_o = K_CJNE;
         8'b1011_1???: kind_o = K_CJNE;
         8'hD5:        kind_o = K_DJNZ;
         8'b1101_1???: kind_o = K_DJNZ;
         8'h73:        kind_o = K_IND;
         default:      kind_o = K_SEQ;
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int DW = 8
) (
   input  xfer_kind_e    kind_i,
   input  logic          cy_i,
   input  logic [DW-1:0] acc_i,
   input  logic          bit_i,
   input  logic [DW-1:0] lhs_i,
   input  logic [DW-1:0] rhs_i,
   input  logic [DW-1:0] cnt_i,
   output logic          taken_o,
   output logic          bit_clr_o,
   output logic          cy_o,
   output logic [DW-1:0] cnt_o
);

   logic acc_zero;
   logic differ;
   logic below;

   assign acc_zero = (acc_i == '0);
   assign differ   = (lhs_i != rhs_i);
   assign below    = (lhs_i < rhs_i);
   assign cnt_o    = cnt_i - DW'(1);

   always_comb begin
      unique case (kind_i)
         K_SEQ:   taken_o = 1'b0;
         K_JC:    taken_o = cy_i;
         K_JNC:   taken_o = !cy_i;
         K_JZ:    taken_o = acc_zero;
         K_JNZ:   taken_o = !acc_zero;
         K_JB:    taken_o = bit_i;
         K_JNB:   taken_o = !bit_i;
         K_JBC:   taken_o = bit_i;
         K_CJNE:  taken_o = differ;
         K_DJNZ:  taken_o = (cnt_o != '0);
         default: taken_o = 1'b1;
      endcase
   end

   assign bit_clr_o = (kind_i == K_JBC) && bit_i;
   assign cy_o      = (kind_i == K_CJNE) ? below : cy_i;

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int ABS_W = 11,
   localparam int PAGE_W = ABS_W - DW
) (
   input  xfer_kind_e        kind_i,
   input  logic [AW-1:0]     pc_i,
   input  logic [1:0]        len_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [DW-1:0]     opa_i,
   input  logic [DW-1:0]     opb_i,
   input  logic [DW-1:0]     acc_i,
   input  logic [AW-1:0]     dptr_i,
   output logic [AW-1:0]     seq_o,
   output logic [AW-1:0]     tgt_o
);

   logic [DW-1:0] disp;
   logic [AW-1:0] disp_ext;
   logic [AW-1:0] abs_tgt;
   logic [AW-1:0] long_tgt;
   logic [AW-1:0] rel_tgt;
   logic [AW-1:0] ind_tgt;

   assign seq_o    = pc_i + AW'(len_i);
   assign disp     = (len_i == 2'd3) ? opb_i : opa_i;
   assign disp_ext = {{(AW-DW){disp[DW-1]}}, disp};
   assign rel_tgt  = seq_o + disp_ext;
   assign abs_tgt  = {seq_o[AW-1:ABS_W], page_i, opa_i};
   assign long_tgt = {opa_i, opb_i};
   assign ind_tgt  = dptr_i + {{(AW-DW){1'b0}}, acc_i};

   always_comb begin
      unique case (kind_i)
         K_SEQ:                   tgt_o = seq_o;
         K_ABS_JMP, K_ABS_CALL:   tgt_o = abs_tgt;
         K_LONG_JMP, K_LONG_CALL: tgt_o = long_tgt;
         K_IND:                   tgt_o = ind_tgt;
         default:                 tgt_o = rel_tgt;
      endcase
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int ABS_W = 11,
   localparam int PAGE_W = ABS_W - DW
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          step_i,
   input  logic [AW-1:0] pc_i,
   input  logic [7:0]    opcode_i,
   input  logic [1:0]    len_i,
   input  logic [DW-1:0] opa_i,
   input  logic [DW-1:0] opb_i,
   input  logic [DW-1:0] acc_i,
   input  logic [AW-1:0] dptr_i,
   input  logic          cy_i,
   input  logic          bit_i,
   input  logic [DW-1:0] cmp_lhs_i,
   input  logic [DW-1:0] cmp_rhs_i,
   input  logic [DW-1:0] cnt_i,
   output logic          valid_o,
   output logic [AW-1:0] npc_o,
   output logic          taken_o,
   output logic          call_o,
   output logic [AW-1:0] ret_addr_o,
   output logic          bit_clr_o,
   output logic          cy_o,
   output logic [DW-1:0] cnt_o
);

   generate
      if (ABS_W <= DW || PAGE_W > 3) begin : g_bad_page
         $error("npc_unit: page field must be 1..3 opcode bits");
      end
      if (AW != 2 * DW) begin : g_bad_long
         $error("npc_unit: long target needs AW equal to two operand bytes");
      end
      if (ABS_W >= AW) begin : g_bad_abs
         $error("npc_unit: in-page field must be narrower than the address");
      end
   endgenerate

   xfer_kind_e    kind;
   logic          taken_d;
   logic          clr_d;
   logic          cy_d;
   logic [DW-1:0] cnt_d;
   logic [AW-1:0] seq_d;
   logic [AW-1:0] tgt_d;
   logic          call_d;

   npc_decode i_decode (
      .opcode_i (opcode_i),
      .kind_o   (kind)
   );

   npc_cond #(.DW(DW)) i_cond (
      .kind_i    (kind),
      .cy_i      (cy_i),
      .acc_i     (acc_i),
      .bit_i     (bit_i),
      .lhs_i     (cmp_lhs_i),
      .rhs_i     (cmp_rhs_i),
      .cnt_i     (cnt_i),
      .taken_o   (taken_d),
      .bit_clr_o (clr_d),
      .cy_o      (cy_d),
      .cnt_o     (cnt_d)
   );

   npc_target #(.AW(AW), .DW(DW), .ABS_W(ABS_W)) i_target (
      .kind_i (kind),
      .pc_i   (pc_i),
      .len_i  (len_i),
      .page_i (opcode_i[7 -: PAGE_W]),
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .acc_i  (acc_i),
      .dptr_i (dptr_i),
      .seq_o  (seq_d),
      .tgt_o  (tgt_d)
   );

   assign call_d = (kind == K_ABS_CALL) || (kind == K_LONG_CALL);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
      end else begin
         valid_o <= step_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         npc_o      <= '0;
         taken_o    <= 1'b0;
         call_o     <= 1'b0;
         ret_addr_o <= '0;
         bit_clr_o  <= 1'b0;
         cy_o       <= 1'b0;
         cnt_o      <= '0;
      end else if (step_i) begin
         npc_o      <= taken_d ? tgt_d : seq_d;
         taken_o    <= taken_d;
         call_o     <= call_d;
         ret_addr_o <= seq_d;
         bit_clr_o  <= clr_d;
         cy_o       <= cy_d;
         cnt_o      <= cnt_d;
      end
   end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          step_i,
   input logic [AW-1:0] pc_i,
   input logic [7:0]    opcode_i,
   input logic [1:0]    len_i,
   input logic [DW-1:0] cnt_i,
   input logic          valid_o,
   input logic [AW-1:0] npc_o,
   input logic          taken_o,
   input logic          call_o,
   input logic [AW-1:0] ret_addr_o,
   input logic          bit_clr_o,
   input logic [DW-1:0] cnt_o
);

   p_fallthrough_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |=> (taken_o || npc_o == AW'($past(pc_i) + AW'($past(len_i)))));

   p_page_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && opcode_i[4:0] == 5'b00001) |=>
      (taken_o && npc_o[10:8] == $past(opcode_i[7:5]) && npc_o[AW-1:11] == ret_addr_o[AW-1:11]));

   p_ret_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |=> (ret_addr_o == AW'($past(pc_i) + AW'($past(len_i)))));

   p_call_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      call_o |-> taken_o);

   p_clr_needs_taken_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_clr_o |-> taken_o);

   p_loop_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && (opcode_i == 8'hD5 || opcode_i[7:3] == 5'b11011)) |=>
      (cnt_o == DW'($past(cnt_i) - DW'(1)) && taken_o == (cnt_o != '0)));

   p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !step_i |=> (!valid_o && $stable(npc_o) && $stable(ret_addr_o) && $stable(taken_o)));

endmodule

bind npc_unit npc_unit_chk #(.AW(AW), .DW(DW)) i_npc_unit_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .step_i     (step_i),
   .pc_i       (pc_i),
   .opcode_i   (opcode_i),
   .len_i      (len_i),
   .cnt_i      (cnt_i),
   .valid_o    (valid_o),
   .npc_o      (npc_o),
   .taken_o    (taken_o),
   .call_o     (call_o),
   .ret_addr_o (ret_addr_o),
   .bit_clr_o  (bit_clr_o),
   .cnt_o      (cnt_o)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step = 1'b0;
   logic [15:0] pc = '0;
   logic [7:0]  opc = '0;
   logic [1:0]  len = 2'd1;
   logic [7:0]  opa = '0;
   logic [7:0]  opb = '0;
   logic [7:0]  acc = '0;
   logic [15:0] dptr = '0;
   logic        cy = 1'b0;
   logic        bitv = 1'b0;
   logic [7:0]  lhs = '0;
   logic [7:0]  rhs = '0;
   logic [7:0]  cnt = '0;
   logic        valid;
   logic [15:0] npc;
   logic        taken;
   logic        call;
   logic [15:0] ret;
   logic        bclr;
   logic        cyo;
   logic [7:0]  cnto;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   npc_unit i_npc_unit (
      .clk_i(clk), .rst_ni(rst_n), .step_i(step), .pc_i(pc), .opcode_i(opc),
      .len_i(len), .opa_i(opa), .opb_i(opb), .acc_i(acc), .dptr_i(dptr),
      .cy_i(cy), .bit_i(bitv), .cmp_lhs_i(lhs), .cmp_rhs_i(rhs), .cnt_i(cnt),
      .valid_o(valid), .npc_o(npc), .taken_o(taken), .call_o(call),
      .ret_addr_o(ret), .bit_clr_o(bclr), .cy_o(cyo), .cnt_o(cnto)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // present one instruction for one cycle, then sample after the capturing edge
   task automatic issue(input logic [15:0] a, input logic [7:0] o, input logic [1:0] l,
                        input logic [7:0] b1, input logic [7:0] b2);
      @(negedge clk);
      pc = a; opc = o; len = l; opa = b1; opb = b2; step = 1'b1;
      @(negedge clk);
      step = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 valid", valid, 0);
      chk("R1 npc", npc, 0);
      chk("R1 taken/call/clr/cy", {taken, call, bclr, cyo}, 0);
      chk("R1 ret/cnt", {ret, cnto}, 0);
   endtask

   task automatic t_sequential;
      cy = 1'b1;
      issue(16'h1234, 8'h00, 2'd1, 8'h00, 8'h00);
      chk("R2 valid", valid, 1);
      chk("R2 npc", npc, 16'h1235);
      chk("R2 taken", taken, 0);
      chk("R9 carry passes", cyo, 1);
      issue(16'hFFFF, 8'hE5, 2'd2, 8'h11, 8'h00);
      chk("R2 wrap", npc, 16'h0001);
      cy = 1'b0;
   endtask

   task automatic t_absolute;
      issue(16'h37FE, 8'hA1, 2'd2, 8'h5C, 8'h00);
      chk("R3 jump target", npc, 16'h3D5C);
      chk("R5 jump no call", {taken, call}, 2'b10);
      issue(16'h1200, 8'hF1, 2'd2, 8'h33, 8'h00);
      chk("R3 call target", npc, 16'h1733);
      chk("R5 call flag", {taken, call}, 2'b11);
      chk("R5 call return", ret, 16'h1202);
   endtask

   task automatic t_long;
      issue(16'h0100, 8'h02, 2'd3, 8'hBE, 8'hEF);
      chk("R4 long jump", npc, 16'hBEEF);
      chk("R5 long jump no call", call, 0);
      issue(16'hFFFE, 8'h12, 2'd3, 8'h40, 8'h00);
      chk("R4 long call", npc, 16'h4000);
      chk("R5 long call return wraps", ret, 16'h0001);
      chk("R5 long call flag", call, 1);
   endtask

   task automatic t_relative;
      issue(16'h2000, 8'h80, 2'd2, 8'hFE, 8'h00);
      chk("R6 back two", npc, 16'h2000);
      issue(16'h2000, 8'h80, 2'd2, 8'h7F, 8'h00);
      chk("R6 max forward", npc, 16'h2081);
      issue(16'h2000, 8'h80, 2'd2, 8'h80, 8'h00);
      chk("R6 max backward", npc, 16'h1F82);
      issue(16'h0000, 8'h80, 2'd2, 8'h80, 8'h00);
      chk("R6 wrap below zero", npc, 16'hFF82);
   endtask

   task automatic t_flags;
      cy = 1'b1;
      issue(16'h0300, 8'h40, 2'd2, 8'h10, 8'h00);
      chk("R7 carry set taken", {taken, npc}, {1'b1, 16'h0312});
      issue(16'h0300, 8'h50, 2'd2, 8'h10, 8'h00);
      chk("R7 no-carry skip", {taken, npc}, {1'b0, 16'h0302});
      cy = 1'b0;
      issue(16'h0300, 8'h40, 2'd2, 8'h10, 8'h00);
      chk("R7 carry clear skip", {taken, npc}, {1'b0, 16'h0302});
      acc = 8'h00;
      issue(16'h0400, 8'h60, 2'd2, 8'h05, 8'h00);
      chk("R7 zero taken", {taken, npc}, {1'b1, 16'h0407});
      acc = 8'h01;
      issue(16'h0400, 8'h60, 2'd2, 8'h05, 8'h00);
      chk("R7 zero skip", {taken, npc}, {1'b0, 16'h0402});
      acc = 8'h80;
      issue(16'h0400, 8'h70, 2'd2, 8'h05, 8'h00);
      chk("R7 nonzero taken", {taken, npc}, {1'b1, 16'h0407});
   endtask

   task automatic t_bits;
      bitv = 1'b1;
      issue(16'h0500, 8'h20, 2'd3, 8'h22, 8'h06);
      chk("R8 bit set taken", {taken, bclr, npc}, {2'b10, 16'h0509});
      issue(16'h0500, 8'h30, 2'd3, 8'h22, 8'h06);
      chk("R8 not-set skip", {taken, npc}, {1'b0, 16'h0503});
      issue(16'h0500, 8'h10, 2'd3, 8'h22, 8'h06);
      chk("R8 test-clear taken", {taken, bclr, npc}, {2'b11, 16'h0509});
      bitv = 1'b0;
      issue(16'h0500, 8'h10, 2'd3, 8'h22, 8'h06);
      chk("R8 test-clear skip", {taken, bclr, npc}, {2'b00, 16'h0503});
   endtask

   task automatic t_compare;
      cy = 1'b1;
      lhs = 8'h10; rhs = 8'h20;
      issue(16'h0600, 8'hB4, 2'd3, 8'h20, 8'hF0);
      chk("R9 less taken", {taken, cyo, npc}, {2'b11, 16'h05F3});
      lhs = 8'h20;
      issue(16'h0600, 8'hBF, 2'd3, 8'h20, 8'hF0);
      chk("R9 equal skip clears carry", {taken, cyo, npc}, {2'b00, 16'h0603});
      lhs = 8'hFF; rhs = 8'h01;
      issue(16'h0600, 8'hB8, 2'd3, 8'h01, 8'hF0);
      chk("R9 greater taken", {taken, cyo}, 2'b10);
      cy = 1'b0;
   endtask

   task automatic t_loop;
      cnt = 8'h01;
      issue(16'h0700, 8'hD8, 2'd2, 8'hFC, 8'h00);
      chk("R10 reaches zero", {taken, cnto, npc}, {1'b0, 8'h00, 16'h0702});
      cnt = 8'h00;
      issue(16'h0700, 8'hDF, 2'd2, 8'hFC, 8'h00);
      chk("R10 wraps and branches", {taken, cnto, npc}, {1'b1, 8'hFF, 16'h06FE});
      cnt = 8'h05;
      issue(16'h0710, 8'hD5, 2'd3, 8'h30, 8'h03);
      chk("R10 direct form", {taken, cnto, npc}, {1'b1, 8'h04, 16'h0716});
   endtask

   task automatic t_indirect;
      dptr = 16'hFFF0; acc = 8'h20;
      issue(16'h0800, 8'h73, 2'd1, 8'h00, 8'h00);
      chk("R11 wrap", {taken, npc}, {1'b1, 16'h0010});
      dptr = 16'h1000; acc = 8'hFF;
      issue(16'h0800, 8'h73, 2'd1, 8'h00, 8'h00);
      chk("R11 unsigned acc", npc, 16'h10FF);
   endtask

   task automatic t_hold;
      issue(16'h0100, 8'h02, 2'd3, 8'hAB, 8'hCD);
      @(negedge clk);
      pc = 16'h5555; opc = 8'h12; opa = 8'h11; opb = 8'h22;
      @(negedge clk);
      chk("R12 valid low", valid, 0);
      chk("R12 npc held", npc, 16'hABCD);
      chk("R12 call held", {taken, call, ret}, {2'b10, 16'h0103});
   endtask

   initial begin
      #1_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sequential();
      t_absolute();
      t_long();
      t_relative();
      t_flags();
      t_bits();
      t_compare();
      t_loop();
      t_indirect();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule